// File: doc/BRIEF.md
# Dual-Bank ROM Address Decoder

This block decodes a 16-bit read address for two 8K read-only banks, X and Y. Each bank is placed on an 8K boundary by a 3-bit base setting. It holds eight 1K sockets, each with its own "populated" flag. It has two flags that say whether RAM also lives in its lower or upper 4K half, and it has an enable. For each address the block produces one-hot socket selects per bank and the 10-bit location inside the chip. It also produces a resident-hit flag, an active-low request that holds off RAM, a flag that tells the access timer that RAM shares the hit region, and a module-select that starts the timer.

The block also places the bank read data on a 16-bit output bus. In wide mode bank X fills the low byte and bank Y fills the high byte. In byte mode the bank that hit fills the low byte.

An active-low ROM-inhibit input makes the block ignore a cycle altogether. In byte mode a double hit (both banks claiming the address) holds off RAM but raises no module-select, so no acknowledge follows. In wide mode the block answers nothing when the two base settings differ.

All outputs are registered. They show the decode of the inputs present at a rising clock edge right after that edge.

Top module: `rom_bank_decoder`

## Requirements
- R1: A bank can hit only when address bits [15:13] equal its 3-bit base setting. A base value b therefore covers addresses b*0x2000 through b*0x2000+0x1FFF.
- R2: Address bits [12:10] pick socket s. A hit in a bank drives that bank's select vector to the value with only bit s set, and drives all zeros otherwise. The chip location output equals address bits [9:0].
- R3: A socket whose populated bit (bit s of the bank's present vector) is 0 produces no select, no resident hit and no RAM inhibit.
- R4: The ram_overlap output is 1 when a bank hits and that bank's no-overlap flag for the hit half is 0. Flag bit 0 covers sockets 0 to 3 and flag bit 1 covers sockets 4 to 7. In every other case ram_overlap is 0.
- R5: Any hit in either bank drives res_hit to 1 and ram_inh_n to 0. With no hit, ram_inh_n is 1.
- R6: While rom_inh_n is 0, all selects, res_hit, mod_sel, ram_overlap and data_oe are 0 and ram_inh_n is 1.
- R7: mod_sel is 1 only when there is a hit and rd_n is 0 in the same cycle.
- R8: In byte mode (wide_mode=0), a hit in both banks at once drives mod_sel to 0 while ram_inh_n stays 0.
- R9: In wide mode (wide_mode=1) with x_base different from y_base, no bank hits for any address.
- R10: A bank whose enable input is 0 never hits.
- R11: While mod_sel is 1, the data bus is set as follows. In wide mode, bits [7:0] carry the X data if X hit and are 0 otherwise, and bits [15:8] carry the Y data if Y hit and are 0 otherwise. In byte mode, bits [7:0] carry the X data if X hit, otherwise the Y data, and bits [15:8] are 0.
- R12: data_oe equals mod_sel. data_out is all zeros whenever data_oe is 0.
- R13: While rst_n is 0, all selects, res_hit, ram_overlap, mod_sel, data_oe, data_out and chip_addr are 0 and ram_inh_n is 1. Out of reset, each output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Read address |
| rd_n | input | 1 | Active-low read command |
| rom_inh_n | input | 1 | Active-low request to ignore this cycle |
| wide_mode | input | 1 | 1: 16-bit data, 0: 8-bit data |
| x_base | input | 3 | Bank X 8K base setting |
| y_base | input | 3 | Bank Y 8K base setting |
| x_present | input | 8 | Bank X populated-socket flags |
| y_present | input | 8 | Bank Y populated-socket flags |
| x_noovl | input | 2 | Bank X no-RAM-overlap flags, bit 0 lower half, bit 1 upper half |
| y_noovl | input | 2 | Bank Y no-RAM-overlap flags, bit 0 lower half, bit 1 upper half |
| x_enable | input | 1 | Bank X enable |
| y_enable | input | 1 | Bank Y enable |
| x_rdata | input | 8 | Bank X read data |
| y_rdata | input | 8 | Bank Y read data |
| x_sel | output | 8 | Bank X one-hot socket select |
| y_sel | output | 8 | Bank Y one-hot socket select |
| chip_addr | output | 10 | Location inside the selected chip |
| res_hit | output | 1 | A populated socket in either bank was hit |
| ram_inh_n | output | 1 | Active-low request to hold off RAM |
| ram_overlap | output | 1 | RAM shares the half that was hit |
| mod_sel | output | 1 | Module select for the access timer |
| data_out | output | 16 | Steered read data |
| data_oe | output | 1 | Data bus driven |

## Verification
The hardest case to reach is the byte-mode double hit. Both banks must share a base, both must be enabled, and the same socket must be populated in both. Only then does mod_sel drop while ram_inh_n stays asserted. The bench sets equal bases and interleaved, partly shared present patterns, then sweeps every 1K window of the address space. As a result, single hits, double hits and misses all occur in one pass. The wide-mode base mismatch also leaves the block silent across the whole sweep, which the bench shows against a populated, fully enabled setup.

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder #(
  parameter int ADDR_W    = 16,
  parameter int SOCK_BITS = 3,
  parameter int CHIP_W    = 10,
  parameter int BYTE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          rd_n,
  input  logic                          rom_inh_n,
  input  logic                          wide_mode,
  input  logic [ADDR_W-SOCK_BITS-CHIP_W-1:0] x_base,
  input  logic [ADDR_W-SOCK_BITS-CHIP_W-1:0] y_base,
  input  logic [(1<<SOCK_BITS)-1:0]     x_present,
  input  logic [(1<<SOCK_BITS)-1:0]     y_present,
  input  logic [1:0]                    x_noovl,
  input  logic [1:0]                    y_noovl,
  input  logic                          x_enable,
  input  logic                          y_enable,
  input  logic [BYTE_W-1:0]             x_rdata,
  input  logic [BYTE_W-1:0]             y_rdata,
  output logic [(1<<SOCK_BITS)-1:0]     x_sel,
  output logic [(1<<SOCK_BITS)-1:0]     y_sel,
  output logic [CHIP_W-1:0]             chip_addr,
  output logic                          res_hit,
  output logic                          ram_inh_n,
  output logic                          ram_overlap,
  output logic                          mod_sel,
  output logic [2*BYTE_W-1:0]           data_out,
  output logic                          data_oe
);
  localparam int BASE_W  = ADDR_W - SOCK_BITS - CHIP_W;
  localparam int SOCKETS = 1 << SOCK_BITS;

  logic [SOCK_BITS-1:0] sock;
  logic [BASE_W-1:0]    blk;
  logic                 half;
  logic                 base_ok, x_hit, y_hit, any_hit, clash, ms_nxt, ovl_nxt;
  logic [SOCKETS-1:0]   onehot;
  logic [2*BYTE_W-1:0]  data_nxt;

  assign sock    = addr[CHIP_W +: SOCK_BITS];
  assign blk     = addr[ADDR_W-1 -: BASE_W];
  assign half    = sock[SOCK_BITS-1];
  assign base_ok = !wide_mode || (x_base == y_base);
  assign x_hit   = rom_inh_n && base_ok && x_enable && (blk == x_base) && x_present[sock];
  assign y_hit   = rom_inh_n && base_ok && y_enable && (blk == y_base) && y_present[sock];
  assign any_hit = x_hit || y_hit;
  assign clash   = x_hit && y_hit && !wide_mode;
  assign ms_nxt  = any_hit && !rd_n && !clash;
  assign ovl_nxt = (x_hit && !x_noovl[half]) || (y_hit && !y_noovl[half]);
  assign onehot  = SOCKETS'(1) << sock;

  always_comb begin
    data_nxt = '0;
    if (ms_nxt) begin
      if (wide_mode) begin
        if (x_hit) data_nxt[BYTE_W-1:0]        = x_rdata;
        if (y_hit) data_nxt[2*BYTE_W-1:BYTE_W] = y_rdata;
      end else begin
        data_nxt[BYTE_W-1:0] = x_hit ? x_rdata : y_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_sel       <= '0;
      y_sel       <= '0;
      chip_addr   <= '0;
      res_hit     <= 1'b0;
      ram_inh_n   <= 1'b1;
      ram_overlap <= 1'b0;
      mod_sel     <= 1'b0;
      data_out    <= '0;
      data_oe     <= 1'b0;
    end else begin
      x_sel       <= x_hit ? onehot : '0;
      y_sel       <= y_hit ? onehot : '0;
      chip_addr   <= addr[CHIP_W-1:0];
      res_hit     <= any_hit;
      ram_inh_n   <= !any_hit;
      ram_overlap <= ovl_nxt;
      mod_sel     <= ms_nxt;
      data_out    <= data_nxt;
      data_oe     <= ms_nxt;
    end
  end
endmodule

// File: rtl/rom_bank_decoder_chk.sv
module rom_bank_decoder_chk #(
  parameter int ADDR_W    = 16,
  parameter int SOCK_BITS = 3,
  parameter int CHIP_W    = 10,
  parameter int BYTE_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             addr,
  input logic                          rd_n,
  input logic                          rom_inh_n,
  input logic                          wide_mode,
  input logic [ADDR_W-SOCK_BITS-CHIP_W-1:0] x_base,
  input logic [ADDR_W-SOCK_BITS-CHIP_W-1:0] y_base,
  input logic [(1<<SOCK_BITS)-1:0]     x_present,
  input logic [(1<<SOCK_BITS)-1:0]     y_present,
  input logic                          x_enable,
  input logic                          y_enable,
  input logic [(1<<SOCK_BITS)-1:0]     x_sel,
  input logic [(1<<SOCK_BITS)-1:0]     y_sel,
  input logic                          ram_inh_n,
  input logic                          mod_sel,
  input logic [2*BYTE_W-1:0]           data_out,
  input logic                          data_oe
);
  localparam int BASE_W = ADDR_W - SOCK_BITS - CHIP_W;

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_sel) && $onehot0(y_sel));

  p_sel_inhibits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_sel != '0) || (y_sel != '0)) |-> !ram_inh_n);

  p_rom_inh_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_inh_n |=> (!mod_sel && ram_inh_n && x_sel == '0 && y_sel == '0));

  p_read_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> !mod_sel);

  p_double_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && rom_inh_n && x_enable && y_enable && x_base == y_base &&
     addr[ADDR_W-1 -: BASE_W] == x_base &&
     x_present[addr[CHIP_W +: SOCK_BITS]] && y_present[addr[CHIP_W +: SOCK_BITS]])
    |=> (!mod_sel && !ram_inh_n));

  p_wide_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && x_base != y_base) |=> (ram_inh_n && !mod_sel));

  p_bank_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !x_enable |=> (x_sel == '0));

  p_oe_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

bind rom_bank_decoder rom_bank_decoder_chk chk_i (.*);

// File: tb/rom_bank_decoder_tb_top.sv
`timescale 1ns/1ps
module rom_bank_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd_n = 1'b1, rom_inh_n = 1'b1, wide_mode = 1'b0;
  logic [2:0] x_base = '0, y_base = '0;
  logic [7:0] x_present = '0, y_present = '0;
  logic [1:0] x_noovl = 2'b11, y_noovl = 2'b11;
  logic x_enable = 1'b1, y_enable = 1'b1;
  logic [7:0] x_rdata = '0, y_rdata = '0;
  logic [7:0] x_sel, y_sel;
  logic [9:0] chip_addr;
  logic res_hit, ram_inh_n, ram_overlap, mod_sel, data_oe;
  logic [15:0] data_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rom_bank_decoder dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_and_check(input string st);
    logic [2:0] s;
    logic xh, yh, any, ms, ovl;
    logic [15:0] d;
    s   = addr[12:10];
    xh  = rom_inh_n && x_enable && addr[15:13] == x_base && x_present[s] && (!wide_mode || x_base == y_base);
    yh  = rom_inh_n && y_enable && addr[15:13] == y_base && y_present[s] && (!wide_mode || x_base == y_base);
    any = xh || yh;
    ms  = any && !rd_n && !(xh && yh && !wide_mode);
    ovl = (xh && !x_noovl[s[2]]) || (yh && !y_noovl[s[2]]);
    d   = '0;
    if (ms) d = wide_mode ? {yh ? y_rdata : 8'h00, xh ? x_rdata : 8'h00}
                          : {8'h00, xh ? x_rdata : y_rdata};
    @(posedge clk); #1;
    chk({st, " R2 x_sel"}, 32'(x_sel), xh ? 32'(8'h1 << s) : 0);
    chk({st, " R2 y_sel"}, 32'(y_sel), yh ? 32'(8'h1 << s) : 0);
    chk({st, " R2 chip_addr"}, 32'(chip_addr), 32'(addr[9:0]));
    chk({st, " R5 res_hit"}, 32'(res_hit), 32'(any));
    chk({st, " R5 ram_inh_n"}, 32'(ram_inh_n), 32'(!any));
    chk({st, " R4 ram_overlap"}, 32'(ram_overlap), 32'(ovl));
    chk({st, " R7 mod_sel"}, 32'(mod_sel), 32'(ms));
    chk({st, " R11 data_out"}, 32'(data_out), 32'(d));
    chk({st, " R12 data_oe"}, 32'(data_oe), 32'(ms));
  endtask

  task automatic sweep(input string st);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      addr    = {a[5:0], 10'((a * 97 + 13) & 10'h3ff)};
      x_rdata = 8'(a * 3 + 1);
      y_rdata = 8'(~(a * 5));
      step_and_check(st);
    end
  endtask

  initial begin
    addr = 16'h6400; x_base = 3'd3; x_present = 8'hff; rom_inh_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 reset x_sel", 32'(x_sel), 0);
    chk("R13 reset ram_inh_n", 32'(ram_inh_n), 1);
    chk("R13 reset mod_sel", 32'(mod_sel), 0);
    chk("R13 reset data", 32'({data_oe, data_out, chip_addr}), 0);
    @(negedge clk); rst_n = 1'b1;

    wide_mode = 0; x_base = 3; y_base = 6; x_present = 8'hff; y_present = 8'hff;
    x_noovl = 2'b11; y_noovl = 2'b11; rd_n = 0; rom_inh_n = 1;
    sweep("R1 bases");
    x_present = 8'b1010_0101; y_present = 8'b0101_1010;
    sweep("R3 present");
    x_noovl = 2'b01; y_noovl = 2'b10;
    sweep("R4 overlap");
    rom_inh_n = 0;
    sweep("R6 rominh");
    rom_inh_n = 1; rd_n = 1;
    sweep("R7 noread");
    rd_n = 0; x_base = 5; y_base = 5; x_present = 8'b1100_1101; y_present = 8'b0110_0111;
    sweep("R8 double");
    wide_mode = 1; x_base = 1; y_base = 4; x_present = 8'hff; y_present = 8'hff;
    sweep("R9 mismatch");
    x_base = 2; y_base = 2; x_present = 8'b1011_0001; y_present = 8'b0011_1110;
    sweep("R11 wide");
    wide_mode = 0; x_base = 7; y_base = 0; x_enable = 0;
    sweep("R10 xoff");
    x_enable = 1; y_enable = 0; y_base = 7;
    sweep("R10 yoff");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog R13 actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule